// File: doc/BRIEF.md
# Diagnostic Snapshot Recorder

This block keeps a short history of node health in a ring of fixed-layout records. It watches four live event counters, the operating state of the node and a watchdog trip line. It writes a record on its own whenever a counter reaches its programmed limit, the operating state moves, or the watchdog trips. Each record freezes, in a single clock, the identity and configuration hash, a free-running cycle count, the last SYNC timestamp, a clock offset summary, the state with its reason and error code, and the four counter values.

Capture costs no extra cycles on the monitored paths. The block only samples inputs that are already present. When the ring is full, a new record replaces the oldest one and a sticky flag records the loss. A host drains the ring one record at a time. It selects a word of the oldest unread record, reads it, and then pulses a pop strobe. An occupancy count shows how many records are still waiting.

Top module: `snap_recorder`

## Requirements
- R1: After reset the ring is empty (occupancy 0), the overflow flag is clear, the read data is zero, every counter limit is 0 (disabled), and the remembered state is INIT.
- R2: A change of `state_i` from the value seen in the previous clock captures a record with cause bit 4 set. States are encoded INIT=0, PREOP=1, SAFEOP=2, OP=3, and the state sits in word 5 bits [1:0].
- R3: A rising edge on `wd_trip_i` captures a record with cause bit 5 set. Holding the line high adds no further record.
- R4: Counter k (0 = working-counter anomalies, 1 = CRC errors, 2 = watchdog trips, 3 = timeouts) sets cause bit k once, in the first clock its value is at or above a nonzero limit. It fires again only after the counter has read 0, or after its limit has been written through `lim_we_i`/`lim_sel_i`/`lim_data_i`. A write re-arms the counter in the clock after the write. A limit of 0 never fires.
- R5: Triggers that occur in the same clock produce a single record whose cause mask has all of their bits set.
- R6: Record layout: word 1 identity, word 2 configuration hash, word 3 cycle count, word 4 SYNC timestamp, word 5 {offset[15:0], error code[7:0], reason[5:0], state[1:0]}, word 6 {counter0, counter1}, word 7 {counter2, counter3}. Each counter is 16 bits wide, counter0 and counter2 in the upper halves.
- R7: Word 0 is {schema version[7:0] (parameter, default 8'h01), cause mask[7:0], sequence number[15:0]}. The sequence number starts at 0 after reset and rises by one per captured record.
- R8: All fields of a record are taken from the inputs of the capturing clock, and the record can be read in the clock after that capture.
- R9: `rd_data_o` shows word `rd_word_i` of the oldest unread record, or zero when the ring is empty. `pop_i` discards the oldest record. A pop on an empty ring has no effect.
- R10: `occ_o` counts unread records, from 0 to SLOTS (8).
- R11: A capture into a full ring without a pop in the same clock drops the oldest record and sets `ovf_o`, which stays set until `ovf_clr_i` is pulsed. A pop and a capture in the same clock on a full ring keep occupancy at SLOTS and do not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wkc_i | input | CNT_W | Working-counter anomaly count |
| cnt_crc_i | input | CNT_W | CRC error count |
| cnt_wdt_i | input | CNT_W | Watchdog trip count |
| cnt_tmo_i | input | CNT_W | Timeout count |
| state_i | input | 2 | Current operating state |
| reason_i | input | 6 | Last transition reason |
| err_code_i | input | 8 | Error code |
| wd_trip_i | input | 1 | Watchdog trip line |
| sync_ts_i | input | 32 | Last SYNC timestamp |
| cycle_cnt_i | input | 32 | Free-running cycle count |
| offset_i | input | 16 | Clock offset summary |
| ident_i | input | 32 | Node identity |
| cfg_hash_i | input | 32 | Configuration hash |
| lim_we_i | input | 1 | Counter limit write strobe |
| lim_sel_i | input | 2 | Counter limit select |
| lim_data_i | input | CNT_W | Counter limit value |
| rd_word_i | input | 3 | Word select within the oldest record |
| pop_i | input | 1 | Discard the oldest record |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| rd_data_o | output | 32 | Selected record word |
| occ_o | output | OCC_W | Unread record count |
| ovf_o | output | 1 | Sticky overwrite flag |

## Verification
A wrong arm bit or a stale remembered state shows at the ports in the clock after the bad trigger. Occupancy rises when no record was due, or stays flat when one was, and the cause mask in word 0 then differs from the expected one. A wrong read or write pointer, or a wrong occupancy count, shows up on the next drain. The sequence numbers read back out of order or skip a value, the counter reports the wrong number of records, or the overflow flag disagrees with the number of records dropped. Because the bench compares all eight words of the oldest record after every clock, a wrong field or a capture taken one clock late appears in the very next comparison.

// File: rtl/snap_pkg.sv
`timescale 1ns/1ps
package snap_pkg;
   localparam int REC_WORDS = 8;
   localparam int N_CNT     = 4;
   localparam int CAUSE_W   = 8;
   localparam int FIELD_W   = 16;
   localparam int C_STATE   = 4;
   localparam int C_WDOG    = 5;

   typedef enum logic [1:0] {
      ST_INIT   = 2'd0,
      ST_PREOP  = 2'd1,
      ST_SAFEOP = 2'd2,
      ST_OP     = 2'd3
   } op_state_e;

   typedef logic [REC_WORDS-1:0][31:0] record_t;
endpackage

// File: rtl/snap_trigger.sv
`timescale 1ns/1ps
module snap_trigger
   import snap_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_CNT-1:0][CNT_W-1:0] cnt_i,
   input  logic                        lim_we_i,
   input  logic [1:0]                  lim_sel_i,
   input  logic [CNT_W-1:0]            lim_data_i,
   input  logic [1:0]                  state_i,
   input  logic                        wd_trip_i,
   output logic [CAUSE_W-1:0]          cause_o
);
   logic [N_CNT-1:0] hit;
   logic [N_CNT-1:0] rearm;
   logic [1:0]       st_q;
   logic             wd_q;
   logic             st_chg;
   logic             wd_edge;

   for (genvar g = 0; g < N_CNT; g++) begin : g_lim
      logic [CNT_W-1:0] lim_q;
      logic             armed_q;

      assign hit[g]   = armed_q && (lim_q != '0) && (cnt_i[g] >= lim_q);
      assign rearm[g] = (cnt_i[g] == '0) || (lim_we_i && (lim_sel_i == 2'(g)));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lim_q   <= '0;
            armed_q <= 1'b1;
         end else begin
            if (lim_we_i && (lim_sel_i == 2'(g)))
               lim_q <= lim_data_i;
            if (rearm[g])
               armed_q <= 1'b1;
            else if (hit[g])
               armed_q <= 1'b0;
         end
      end

      // a limit crossing reports once until re-armed
      p_fire_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[g] && !rearm[g]) |=> !hit[g]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_INIT;
         wd_q <= 1'b0;
      end else begin
         st_q <= state_i;
         wd_q <= wd_trip_i;
      end
   end

   assign st_chg  = (state_i != st_q);
   assign wd_edge = wd_trip_i && !wd_q;

   always_comb begin
      cause_o                = '0;
      cause_o[N_CNT-1:0]     = hit;
      cause_o[C_STATE]       = st_chg;
      cause_o[C_WDOG]        = wd_edge;
   end

   // a held trip line must not report twice in a row
   p_wd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cause_o[C_WDOG] |=> !cause_o[C_WDOG]);
endmodule

// File: rtl/snap_ring.sv
`timescale 1ns/1ps
module snap_ring
   import snap_pkg::*;
#(
   parameter int SLOTS = 8,
   localparam int PTR_W = $clog2(SLOTS),
   localparam int OCC_W = $clog2(SLOTS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_i,
   input  record_t          rec_i,
   input  logic [2:0]       rd_word_i,
   input  logic             pop_i,
   input  logic             ovf_clr_i,
   output logic [31:0]      rd_data_o,
   output logic [OCC_W-1:0] occ_o,
   output logic             ovf_o
);
   record_t          mem [SLOTS];
   logic [PTR_W-1:0] wr_q;
   logic [PTR_W-1:0] rd_q;
   logic [OCC_W-1:0] occ_q;
   logic             ovf_q;
   logic             full;
   logic             pop_ok;
   logic             drop;

   assign full   = (occ_q == OCC_W'(SLOTS));
   assign pop_ok = pop_i && (occ_q != '0);
   assign drop   = cap_i && full && !pop_ok;

   always_ff @(posedge clk) begin
      if (cap_i)
         mem[wr_q] <= rec_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         occ_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (cap_i)
            wr_q <= wr_q + 1'b1;
         if (pop_ok || (cap_i && full))
            rd_q <= rd_q + 1'b1;
         if (cap_i && !pop_ok && !full)
            occ_q <= occ_q + 1'b1;
         else if (!cap_i && pop_ok)
            occ_q <= occ_q - 1'b1;
         if (drop)
            ovf_q <= 1'b1;
         else if (ovf_clr_i)
            ovf_q <= 1'b0;
      end
   end

   assign rd_data_o = (occ_q != '0) ? mem[rd_q][rd_word_i] : 32'h0;
   assign occ_o     = occ_q;
   assign ovf_o     = ovf_q;

   p_occ_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= OCC_W'(SLOTS));

   p_occ_grow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_i && !pop_i && !full) |=> (occ_q == $past(occ_q) + 1'b1));

   p_pop_shrink_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !cap_i && occ_q != '0) |=> (occ_q == $past(occ_q) - 1'b1));

   p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !ovf_clr_i) |=> ovf_q);

   p_swap_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_i && pop_i && full && !ovf_q) |=> (full && !ovf_q));
endmodule

// File: rtl/snap_recorder.sv
`timescale 1ns/1ps
module snap_recorder
   import snap_pkg::*;
#(
   parameter int         SLOTS      = 8,
   parameter int         CNT_W      = 16,
   parameter logic [7:0] SCHEMA_VER = 8'h01,
   localparam int        OCC_W      = $clog2(SLOTS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_wkc_i,
   input  logic [CNT_W-1:0] cnt_crc_i,
   input  logic [CNT_W-1:0] cnt_wdt_i,
   input  logic [CNT_W-1:0] cnt_tmo_i,
   input  logic [1:0]       state_i,
   input  logic [5:0]       reason_i,
   input  logic [7:0]       err_code_i,
   input  logic             wd_trip_i,
   input  logic [31:0]      sync_ts_i,
   input  logic [31:0]      cycle_cnt_i,
   input  logic [15:0]      offset_i,
   input  logic [31:0]      ident_i,
   input  logic [31:0]      cfg_hash_i,
   input  logic             lim_we_i,
   input  logic [1:0]       lim_sel_i,
   input  logic [CNT_W-1:0] lim_data_i,
   input  logic [2:0]       rd_word_i,
   input  logic             pop_i,
   input  logic             ovf_clr_i,
   output logic [31:0]      rd_data_o,
   output logic [OCC_W-1:0] occ_o,
   output logic             ovf_o
);
   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 2");
   end
   if (CNT_W < 1 || CNT_W > FIELD_W) begin : g_bad_cnt
      $error("CNT_W must lie between 1 and 16");
   end

   logic [N_CNT-1:0][CNT_W-1:0] cnt_vec;
   logic [CAUSE_W-1:0]          cause;
   logic                        cap;
   logic [15:0]                 seq_q;
   record_t                     rec;

   assign cnt_vec = {cnt_tmo_i, cnt_wdt_i, cnt_crc_i, cnt_wkc_i};

   snap_trigger #(.CNT_W(CNT_W)) u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_i      (cnt_vec),
      .lim_we_i   (lim_we_i),
      .lim_sel_i  (lim_sel_i),
      .lim_data_i (lim_data_i),
      .state_i    (state_i),
      .wd_trip_i  (wd_trip_i),
      .cause_o    (cause)
   );

   assign cap = (cause != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         seq_q <= '0;
      else if (cap)
         seq_q <= seq_q + 1'b1;
   end

   always_comb begin
      rec[0] = {SCHEMA_VER, cause, seq_q};
      rec[1] = ident_i;
      rec[2] = cfg_hash_i;
      rec[3] = cycle_cnt_i;
      rec[4] = sync_ts_i;
      rec[5] = {offset_i, err_code_i, reason_i, state_i};
      rec[6] = {FIELD_W'(cnt_wkc_i), FIELD_W'(cnt_crc_i)};
      rec[7] = {FIELD_W'(cnt_wdt_i), FIELD_W'(cnt_tmo_i)};
   end

   snap_ring #(.SLOTS(SLOTS)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_i     (cap),
      .rec_i     (rec),
      .rd_word_i (rd_word_i),
      .pop_i     (pop_i),
      .ovf_clr_i (ovf_clr_i),
      .rd_data_o (rd_data_o),
      .occ_o     (occ_o),
      .ovf_o     (ovf_o)
   );

   // any trigger leaves at least one unread record
   p_cap_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (occ_o != '0));

   // a state move is always recorded
   p_state_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i != $past(state_i) && $past(rst_n)) |-> cap);
endmodule

// File: tb/snap_recorder_test.sv
`timescale 1ns/1ps
module snap_recorder_test;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n;
   logic [15:0] c_wkc, c_crc, c_wdt, c_tmo;
   logic [1:0]  st;
   logic [5:0]  rsn;
   logic [7:0]  ecode;
   logic        wd;
   logic [31:0] sts, ccnt, idv, hsh;
   logic [15:0] ofs;
   logic        lwe;
   logic [1:0]  lsel;
   logic [15:0] ldat;
   logic [2:0]  rw;
   logic        pop, oclr;
   wire  [31:0] rdat;
   wire  [3:0]  occ;
   wire         ovf;

   int checks = 0;
   int errors = 0;

   logic [15:0] m_lim [4];
   logic        m_arm [4];
   logic [1:0]  m_st;
   logic        m_wd;
   logic [15:0] m_seq;
   logic [31:0] m_mem [8][8];
   int          m_wr, m_rd, m_cnt;
   logic        m_ovf;

   snap_recorder uut (
      .clk(clk), .rst_n(rst_n),
      .cnt_wkc_i(c_wkc), .cnt_crc_i(c_crc), .cnt_wdt_i(c_wdt), .cnt_tmo_i(c_tmo),
      .state_i(st), .reason_i(rsn), .err_code_i(ecode), .wd_trip_i(wd),
      .sync_ts_i(sts), .cycle_cnt_i(ccnt), .offset_i(ofs), .ident_i(idv),
      .cfg_hash_i(hsh), .lim_we_i(lwe), .lim_sel_i(lsel), .lim_data_i(ldat),
      .rd_word_i(rw), .pop_i(pop), .ovf_clr_i(oclr),
      .rd_data_o(rdat), .occ_o(occ), .ovf_o(ovf)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] cval(int i);
      case (i)
         0: return c_wkc;
         1: return c_crc;
         2: return c_wdt;
         default: return c_tmo;
      endcase
   endfunction

   // record layout per R6 and R7
   function automatic logic [31:0] recw(int w, logic [7:0] cause, logic [15:0] seq);
      case (w)
         0: return {8'h01, cause, seq};
         1: return idv;
         2: return hsh;
         3: return ccnt;
         4: return sts;
         5: return {ofs, ecode, rsn, st};
         6: return {c_wkc, c_crc};
         default: return {c_wdt, c_tmo};
      endcase
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 4; i++) begin
         m_lim[i] = '0;
         m_arm[i] = 1'b1;
      end
      m_st = 2'd0; m_wd = 1'b0; m_seq = '0;
      m_wr = 0; m_rd = 0; m_cnt = 0; m_ovf = 1'b0;
   endtask

   task automatic model_step();
      logic [7:0] cause = '0;
      bit popok, full;
      for (int i = 0; i < 4; i++) begin
         logic [15:0] v = cval(i);
         bit hit = m_arm[i] && (m_lim[i] != 0) && (v >= m_lim[i]);
         bit re  = (v == 0) || (lwe && lsel == 2'(i));
         if (hit) cause[i] = 1'b1;
         if (re) m_arm[i] = 1'b1;
         else if (hit) m_arm[i] = 1'b0;
         if (lwe && lsel == 2'(i)) m_lim[i] = ldat;
      end
      if (st != m_st) cause[4] = 1'b1;
      if (wd && !m_wd) cause[5] = 1'b1;
      m_st = st; m_wd = wd;
      popok = pop && (m_cnt != 0);
      full  = (m_cnt == 8);
      if (cause != 0) begin
         for (int w = 0; w < 8; w++) m_mem[m_wr][w] = recw(w, cause, m_seq);
         m_seq++;
         m_wr = (m_wr + 1) % 8;
      end
      if (popok || (cause != 0 && full)) m_rd = (m_rd + 1) % 8;
      if (cause != 0 && !popok && !full) m_cnt++;
      else if (cause == 0 && popok) m_cnt--;
      if (cause != 0 && full && !popok) m_ovf = 1'b1;
      else if (oclr) m_ovf = 1'b0;
   endtask

   task automatic rdw(int w, output logic [31:0] v);
      rw = 3'(w);
      #0.1;
      v = rdat;
      rw = 3'd0;
   endtask

   task automatic compare();
      logic [31:0] v;
      chk("R10 occupancy", 32'(occ), 32'(m_cnt));
      chk("R11 overflow flag", 32'(ovf), 32'(m_ovf));
      for (int w = 0; w < 8; w++) begin
         rdw(w, v);
         chk("R6 R8 R9 record word", v, (m_cnt != 0) ? m_mem[m_rd][w] : 32'h0);
      end
   endtask

   task automatic cyc();
      model_step();
      @(posedge clk);
      @(negedge clk);
      pop = 1'b0; lwe = 1'b0; oclr = 1'b0;
      compare();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      c_wkc = 0; c_crc = 0; c_wdt = 0; c_tmo = 0;
      st = 0; rsn = 0; ecode = 0; wd = 0;
      sts = 0; ccnt = 0; idv = 32'hC0DE_0042; hsh = 32'h5EED_1234; ofs = 0;
      lwe = 0; lsel = 0; ldat = 0; rw = 0; pop = 0; oclr = 0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 occupancy after reset", 32'(occ), 32'd0);
      chk("R1 overflow after reset", 32'(ovf), 32'd0);
      chk("R1 read data after reset", rdat, 32'h0);

      // R2 state change, R6/R7/R8 layout
      st = 2'd1; sts = 32'hA5A5_0001; rsn = 6'h2A; ecode = 8'h7E; ofs = 16'h1234; ccnt = 32'd77;
      cyc();
      chk("R2 one record on state move", 32'(occ), 32'd1);
      rdw(0, v); chk("R7 header after state move", v, 32'h0110_0000);
      rdw(5, v); chk("R2 R6 state word", v, 32'h1234_7EA9);
      rdw(4, v); chk("R8 timestamp of capture clock", v, 32'hA5A5_0001);
      rdw(1, v); chk("R6 identity word", v, 32'hC0DE_0042);
      pop = 1'b1; cyc();
      chk("R9 pop empties", 32'(occ), 32'd0);

      // R5 merged triggers, R3 held trip line
      st = 2'd3; wd = 1'b1; cyc();
      rdw(0, v); chk("R5 merged causes", v, 32'h0130_0001);
      cyc();
      chk("R3 held trip adds nothing", 32'(occ), 32'd1);
      wd = 1'b0; pop = 1'b1; cyc();

      // R4 disabled limit
      c_tmo = 16'd100; cyc();
      chk("R4 zero limit never fires", 32'(occ), 32'd0);

      // R4 crossing, once, re-arm by clear and by write
      lwe = 1'b1; lsel = 2'd1; ldat = 16'd5; cyc();
      chk("R4 limit write alone", 32'(occ), 32'd0);
      c_crc = 16'd5; cyc();
      rdw(0, v); chk("R4 crossing cause", v, 32'h0102_0002);
      rdw(6, v); chk("R6 counter word", v, 32'h0000_0005);
      repeat (3) cyc();
      chk("R4 fires once", 32'(occ), 32'd1);
      pop = 1'b1; c_crc = 16'd0; cyc();
      chk("R4 cleared counter no record", 32'(occ), 32'd0);
      c_crc = 16'd5; cyc();
      rdw(0, v); chk("R4 re-armed by clear", v[15:0], 32'd3);
      pop = 1'b1; cyc();
      lwe = 1'b1; lsel = 2'd1; ldat = 16'd5; cyc();
      chk("R4 write clock no record", 32'(occ), 32'd0);
      cyc();
      rdw(0, v); chk("R4 re-armed by write", v, 32'h0102_0004);
      pop = 1'b1; cyc();

      // R11 overflow
      for (int i = 0; i < 9; i++) begin
         st = (i % 2 == 0) ? 2'd2 : 2'd3;
         cyc();
      end
      chk("R11 full ring", 32'(occ), 32'd8);
      chk("R11 overflow set", 32'(ovf), 32'd1);
      rdw(0, v); chk("R11 oldest dropped", v[15:0], 32'd6);
      oclr = 1'b1; cyc();
      chk("R11 overflow cleared", 32'(ovf), 32'd0);
      pop = 1'b1; st = 2'd3; cyc();
      chk("R11 pop with capture keeps full", 32'(occ), 32'd8);
      chk("R11 pop with capture no overflow", 32'(ovf), 32'd0);
      rdw(0, v); chk("R11 oldest after swap", v[15:0], 32'd7);

      // R9 drain and pop on empty
      repeat (8) begin pop = 1'b1; cyc(); end
      chk("R9 drained", 32'(occ), 32'd0);
      pop = 1'b1; cyc();
      chk("R9 pop on empty", 32'(occ), 32'd0);
      chk("R9 empty read zero", rdat, 32'h0);

      // random phase
      for (int n = 0; n < 3000; n++) begin
         if ($urandom % 40 == 0) c_wkc = 0; else c_wkc = c_wkc + 16'($urandom % 3);
         if ($urandom % 40 == 0) c_crc = 0; else c_crc = c_crc + 16'($urandom % 2);
         if ($urandom % 40 == 0) c_wdt = 0; else c_wdt = c_wdt + 16'($urandom % 2);
         if ($urandom % 40 == 0) c_tmo = 0; else c_tmo = c_tmo + 16'($urandom % 3);
         if ($urandom % 30 == 0) st = 2'($urandom);
         wd = ($urandom % 25 == 0) ? ~wd : wd;
         pop = ($urandom % 4 == 0);
         oclr = ($urandom % 100 == 0);
         if ($urandom % 60 == 0) begin
            lwe = 1'b1; lsel = 2'($urandom); ldat = 16'($urandom % 41);
         end
         sts = $urandom; ccnt = ccnt + 1; rsn = 6'($urandom);
         ecode = 8'($urandom); ofs = 16'($urandom);
         cyc();
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule